// File: doc/BRIEF.md
# AC-Coupled Interconnect Test Pulse Generator

This block sits on the output side of boundary-scan pins. It decides what each pin drives while a board test runs on links that carry a series capacitor. A static level cannot cross such a link, so the block turns the captured update data into edges that the far end can detect. When no test is selected, it passes the functional core value through unchanged. In static interconnect test it drives the update data as a fixed level. In single-pulse mode it drives an inverted excursion for the whole stay in Run-Test/Idle. In train mode it toggles on every TCK cycle spent in Run-Test/Idle.

The TAP controller, the shift stage of the scan cells and the receivers are outside the block. The controller supplies one-cycle-wide state indications and already-decoded test selects. Each pin value is registered, and it changes only on the falling edge of TCK. The sample taken on a falling edge uses the state and data present during the TCK cycle that edge closes. A parameter sets the number of pins. Each pin has its own cell, but all pins share the mode decode and the TAP state inputs.

Top module: `ac_pulse_gen`

## Requirements
- R1: With no test select asserted, each falling edge of TCK loads `pin_drive` with `core_data`.
- R2: With only the static select asserted, each falling edge loads `pin_drive` with `upd_data`, and the value is not inverted in Run-Test/Idle.
- R3: With the pulse or train select asserted, a falling edge in any TAP state other than Run-Test/Idle drives true `upd_data`. This covers Update-IR, Update-DR and the first edge after leaving Run-Test/Idle.
- R4: In pulse mode, every falling edge spent in Run-Test/Idle drives the inverted update data, however long the dwell lasts.
- R5: In train mode, the first falling edge in Run-Test/Idle drives inverted data, and each later edge in the same dwell flips the pin again.
- R6: When several selects are asserted together, train takes precedence over pulse, and pulse over static.
- R7: A falling edge with `tap_reset` high loads `pin_drive` with `core_data` and clears the toggle state. The next train dwell then starts with an inverted edge.
- R8: `pin_drive` never changes on a rising edge of TCK.
- R9: Bit i of `pin_drive` is derived only from bit i of `upd_data` and `core_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; outputs update on its falling edge |
| tap_reset | input | 1 | Test-Logic-Reset indication, synchronous, active high |
| st_update_ir | input | 1 | TAP is in Update-IR this cycle |
| st_update_dr | input | 1 | TAP is in Update-DR this cycle |
| st_run_idle | input | 1 | TAP is in Run-Test/Idle this cycle |
| sel_static | input | 1 | Static interconnect test selected |
| sel_pulse | input | 1 | Single-pulse AC test selected |
| sel_train | input | 1 | Toggle-train AC test selected |
| upd_data | input | PINS | Update-register value for each pin |
| core_data | input | PINS | Functional core output for each pin |
| pin_drive | output | PINS | Registered drive value for each pin |

## Verification
A wrong toggle bit in a cell shows up as a pin of the wrong polarity on the very next falling edge in Run-Test/Idle. In train mode, the error persists as a shifted phase for the rest of the dwell. A stale inversion that is not cleared on leaving the idle state, or on reset, shows up one falling edge later as inverted data in an update or shift state. The bench predicts each pin per edge from its own run-length count. Separately, it compares the pin across every rising edge.

// File: rtl/ac_pulse_pkg.sv
package ac_pulse_pkg;
  typedef enum logic [1:0] {
    DM_FUNC   = 2'd0,
    DM_STATIC = 2'd1,
    DM_PULSE  = 2'd2,
    DM_TRAIN  = 2'd3
  } drive_mode_t;
endpackage

// File: rtl/ac_mode_decode.sv
module ac_mode_decode
  import ac_pulse_pkg::*;
(
  input  logic        sel_static_i,
  input  logic        sel_pulse_i,
  input  logic        sel_train_i,
  input  logic        st_update_ir_i,
  input  logic        st_update_dr_i,
  output drive_mode_t mode_o,
  output logic        in_update_o
);
  // R6: train outranks pulse, pulse outranks static
  always_comb begin
    if (sel_train_i)       mode_o = DM_TRAIN;
    else if (sel_pulse_i)  mode_o = DM_PULSE;
    else if (sel_static_i) mode_o = DM_STATIC;
    else                   mode_o = DM_FUNC;
  end

  assign in_update_o = st_update_ir_i | st_update_dr_i;
endmodule

// File: rtl/ac_pin_cell.sv
module ac_pin_cell
  import ac_pulse_pkg::*;
(
  input  logic        tck_i,
  input  logic        rst_i,
  input  drive_mode_t mode_i,
  input  logic        in_update_i,
  input  logic        in_idle_i,
  input  logic        upd_i,
  input  logic        core_i,
  output logic        pin_o
);
  logic inv_q, inv_d;
  logic pin_q, pin_d;

  always_comb begin
    inv_d = 1'b0;
    pin_d = core_i;
    case (mode_i)
      DM_STATIC: pin_d = upd_i;
      DM_PULSE: begin
        inv_d = in_idle_i;
        pin_d = upd_i ^ in_idle_i;
      end
      DM_TRAIN: begin
        inv_d = in_idle_i & ~inv_q;
        pin_d = upd_i ^ (in_idle_i & ~inv_q);
      end
      default: pin_d = core_i;
    endcase
  end

  always_ff @(negedge tck_i) begin
    if (rst_i) begin
      inv_q <= 1'b0;
      pin_q <= core_i;
    end else begin
      inv_q <= inv_d;
      pin_q <= pin_d;
    end
  end

  assign pin_o = pin_q;

  // one cycle of post-reset history available for $past
  logic live_q;
  always_ff @(negedge tck_i) begin
    if (rst_i) live_q <= 1'b0;
    else       live_q <= 1'b1;
  end

  assert_func_pass_R1: assert property (@(negedge tck_i) disable iff (rst_i)
    (mode_i == DM_FUNC) |=> (pin_o == $past(core_i)));

  assert_static_level_R2: assert property (@(negedge tck_i) disable iff (rst_i)
    (mode_i == DM_STATIC) |=> (pin_o == $past(upd_i)));

  assert_true_outside_idle_R3: assert property (@(negedge tck_i) disable iff (rst_i)
    ((mode_i == DM_PULSE || mode_i == DM_TRAIN) && (in_update_i || !in_idle_i))
      |=> (pin_o == $past(upd_i)));

  assert_pulse_hold_R4: assert property (@(negedge tck_i) disable iff (rst_i)
    (mode_i == DM_PULSE && in_idle_i) |=> (pin_o == !$past(upd_i)));

  assert_train_flip_R5: assert property (@(negedge tck_i) disable iff (rst_i)
    (live_q && mode_i == DM_TRAIN && in_idle_i && $past(mode_i == DM_TRAIN && in_idle_i)
      && $stable(upd_i)) |=> (pin_o != $past(pin_o)));

  assert_reset_clear_R7: assert property (@(negedge tck_i)
    rst_i |=> (pin_o == $past(core_i) && !inv_q));
endmodule

// File: rtl/ac_pulse_gen.sv
module ac_pulse_gen
  import ac_pulse_pkg::*;
#(
  parameter int PINS = 4
) (
  input  logic            tck,
  input  logic            tap_reset,
  input  logic            st_update_ir,
  input  logic            st_update_dr,
  input  logic            st_run_idle,
  input  logic            sel_static,
  input  logic            sel_pulse,
  input  logic            sel_train,
  input  logic [PINS-1:0] upd_data,
  input  logic [PINS-1:0] core_data,
  output logic [PINS-1:0] pin_drive
);
  drive_mode_t mode;
  logic        in_update;

  ac_mode_decode u_decode (
    .sel_static_i   (sel_static),
    .sel_pulse_i    (sel_pulse),
    .sel_train_i    (sel_train),
    .st_update_ir_i (st_update_ir),
    .st_update_dr_i (st_update_dr),
    .mode_o         (mode),
    .in_update_o    (in_update)
  );

  // R9: one independent cell per pin
  for (genvar g = 0; g < PINS; g++) begin : g_cell
    ac_pin_cell u_cell (
      .tck_i       (tck),
      .rst_i       (tap_reset),
      .mode_i      (mode),
      .in_update_i (in_update),
      .in_idle_i   (st_run_idle),
      .upd_i       (upd_data[g]),
      .core_i      (core_data[g]),
      .pin_o       (pin_drive[g])
    );
  end

  // R8: any change of the pins happens while TCK is low
  always @(pin_drive) begin
    assert_fall_only_R8: assert (tck !== 1'b1);
  end
endmodule

// File: tb/ac_pulse_gen_test.sv
module ac_pulse_gen_test;
  localparam int P = 4;
  localparam time HALF = 10ns;

  logic tck = 1'b0;
  logic tap_reset = 1'b1;
  logic st_update_ir = 1'b0, st_update_dr = 1'b0, st_run_idle = 1'b0;
  logic sel_static = 1'b0, sel_pulse = 1'b0, sel_train = 1'b0;
  logic [P-1:0] upd_data = '0, core_data = '0;
  logic [P-1:0] pin_drive;

  int checks = 0;
  int errors = 0;
  int run = 0;
  logic [P-1:0] exp_q[$];
  string tag_q[$];
  logic [P-1:0] last_pin;
  bit armed = 0;
  bit done = 0;

  always #HALF tck = ~tck;

  ac_pulse_gen #(.PINS(P)) uut (
    .tck(tck), .tap_reset(tap_reset),
    .st_update_ir(st_update_ir), .st_update_dr(st_update_dr), .st_run_idle(st_run_idle),
    .sel_static(sel_static), .sel_pulse(sel_pulse), .sel_train(sel_train),
    .upd_data(upd_data), .core_data(core_data), .pin_drive(pin_drive)
  );

  task automatic chk(input bit ok, input string tag, input logic [P-1:0] act, input logic [P-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: apply one TCK cycle of stimulus and push the predicted pin value
  task automatic step(input logic r, input logic ex, input logic pu, input logic tr,
                      input logic uir, input logic udr, input logic idle,
                      input logic [P-1:0] d, input logic [P-1:0] c, input string tag);
    logic [P-1:0] e;
    @(posedge tck);
    tap_reset <= r; sel_static <= ex; sel_pulse <= pu; sel_train <= tr;
    st_update_ir <= uir; st_update_dr <= udr; st_run_idle <= idle;
    upd_data <= d; core_data <= c;
    if (r) begin
      run = 0; e = c;
    end else if (tr) begin
      if (idle) begin
        run++;
        e = (run % 2 == 1) ? ~d : d;
      end else begin
        run = 0; e = d;
      end
    end else if (pu) begin
      run = 0; e = idle ? ~d : d;
    end else if (ex) begin
      run = 0; e = d;
    end else begin
      run = 0; e = c;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compare after each falling edge
  initial forever begin
    @(negedge tck); #5;
    if (exp_q.size() > 0) begin
      logic [P-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(pin_drive === e, t, pin_drive, e);
      last_pin = pin_drive;
      armed = 1;
    end
  end

  // R8: nothing moves across a rising edge
  initial forever begin
    @(posedge tck); #5;
    if (armed) chk(pin_drive === last_pin, "R8 rising edge change", pin_drive, last_pin);
  end

  initial begin
    #(HALF * 2 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R7 reset state: core value passes
    for (int i = 0; i < 3; i++) step(1,0,0,0, 0,0,0, 4'b1111, 4'b0101, "R7 reset passes core");
    // R1 functional pass-through
    step(0,0,0,0, 0,0,0, 4'b1111, 4'b0110, "R1 functional");
    step(0,0,0,0, 0,0,1, 4'b0000, 4'b1001, "R1 functional in idle");
    // R2 static test, no toggle in idle
    step(0,1,0,0, 0,1,0, 4'b1010, 4'b0000, "R2 static update-dr");
    for (int i = 0; i < 3; i++) step(0,1,0,0, 0,0,1, 4'b1010, 4'b1111, "R2 static idle");
    // R3/R4 pulse mode
    step(0,0,1,0, 1,0,0, 4'b0011, 4'b0000, "R3 pulse update-ir");
    step(0,0,1,0, 0,1,0, 4'b1010, 4'b0000, "R3 pulse update-dr");
    step(0,0,1,0, 0,0,0, 4'b1010, 4'b0000, "R3 pulse before idle");
    for (int i = 0; i < 5; i++) step(0,0,1,0, 0,0,1, 4'b1010, 4'b0000, "R4 pulse idle dwell");
    step(0,0,1,0, 0,0,0, 4'b1010, 4'b0000, "R3 pulse after idle");
    step(0,0,1,0, 0,0,0, 4'b1010, 4'b0000, "R3 pulse later");
    // R5 train mode; R9 distinct bits per pin
    step(0,0,0,1, 0,1,0, 4'b1100, 4'b0000, "R3 train update-dr");
    for (int i = 0; i < 5; i++) step(0,0,0,1, 0,0,1, 4'b1100, 4'b0000, "R5 train idle toggle");
    step(0,0,0,1, 0,0,0, 4'b1100, 4'b0000, "R3 train after idle");
    for (int i = 0; i < 2; i++) step(0,0,0,1, 0,0,1, 4'b0110, 4'b1111, "R9 train per-pin");
    step(0,0,0,1, 0,0,0, 4'b0110, 4'b1111, "R3 train leave");
    // R6 priority
    for (int i = 0; i < 3; i++) step(0,0,1,1, 0,0,1, 4'b1001, 4'b0000, "R6 train over pulse");
    for (int i = 0; i < 3; i++) step(0,1,1,0, 0,0,1, 4'b1001, 4'b0000, "R6 pulse over static");
    step(0,1,1,0, 0,0,0, 4'b1001, 4'b0000, "R6 pulse leave");
    // R7 reset mid train dwell clears toggle state
    for (int i = 0; i < 3; i++) step(0,0,0,1, 0,0,1, 4'b0101, 4'b0000, "R5 train before reset");
    step(1,0,0,1, 0,0,1, 4'b0101, 4'b0011, "R7 reset in train");
    step(0,0,0,1, 0,0,1, 4'b0101, 4'b0011, "R7 first train edge inverted");
    step(0,0,0,1, 0,0,1, 4'b0101, 4'b0011, "R5 second train edge");
    step(0,0,0,0, 0,0,0, 4'b0101, 4'b1110, "R1 back to functional");
    repeat (3) @(posedge tck);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule